// File: doc/BRIEF.md
# Hashed Route Cache with Slow-Path Refill

This block sits in a forwarding pipeline and remembers recent destination-to-route decisions so that repeated traffic to the same host avoids the expensive full forwarding table. Each lookup carries a 32-bit destination address. The address is folded by XOR into a set number. Each set holds two entries, and each entry keeps the whole destination address as its tag, so two destinations that land in the same set are still told apart. A matching entry returns its next-hop identifier and output port on the next cycle.

When neither entry matches, the block stops accepting lookups and presents the address to a slower full-table engine over a plain request/response pair. When that engine answers, the block forwards the answer as the lookup result and writes it into the set. An empty entry is used first. If both entries are full, the entry to replace is chosen by a run-time policy select: least recently used, oldest fill first, or a pseudo-random bit. A flush input invalidates the whole cache. Hit and miss counters are exposed so their totals can be checked.

Top module: `rc_route_cache`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), req_ready is 1, rsp_valid is 0, slow_req_valid is 0, and both counters read 0.
- R2: The set number is computed from address A in two steps. First, F = A[31:16] XOR A[15:0]. Second, the bits of F are XOR-folded modulo the index width, so with 4 index bits it is the XOR of all eight nibbles of A. An entry hits only when its stored 32-bit address equals A exactly.
- R3: A lookup accepted on a hit gives rsp_valid=1 and rsp_hit=1 on the following cycle, with the stored next hop and port. No slow request is raised.
- R4: A lookup accepted on a miss raises slow_req_valid on the following cycle, with slow_req_addr equal to the looked-up address. Both are held until slow_rsp_valid is seen. req_ready stays 0 throughout.
- R5: On the cycle after slow_rsp_valid is sampled, rsp_valid=1 and rsp_hit=0, with the returned next hop and port. The route is installed, so the next lookup of that address hits.
- R6: With policy 0 (LRU), a fill into a full set replaces the entry whose last hit or fill is older.
- R7: With policy 1 (FIFO), a fill into a full set replaces the entry that was filled earlier. Hits do not change this order.
- R8: With policy 2 (random), a fill into a full set replaces one of the two entries, chosen by a free-running LFSR bit. The new route hits on its next lookup.
- R9: A flush cycle invalidates every entry, so each later lookup misses until it is refilled. req_ready is 0 while flush is high.
- R10: hit_count increases by one for each lookup accepted on a hit. miss_count increases by one for each lookup accepted on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all entries |
| repl_sel | input | 2 | Replacement policy: 0 LRU, 1 FIFO, 2 random |
| req_valid | input | 1 | Lookup request valid |
| req_addr | input | 32 | Destination address to look up |
| req_ready | output | 1 | Lookup can be accepted this cycle |
| rsp_valid | output | 1 | Lookup result valid (one cycle) |
| rsp_hit | output | 1 | Result came from the cache |
| rsp_nh | output | 8 | Next-hop identifier |
| rsp_port | output | 4 | Output port |
| slow_req_valid | output | 1 | Full-table request pending |
| slow_req_addr | output | 32 | Address sent to the full table |
| slow_rsp_valid | input | 1 | Full-table answer valid |
| slow_rsp_nh | input | 8 | Next hop from the full table |
| slow_rsp_port | input | 4 | Port from the full table |
| hit_count | output | 16 | Number of hits |
| miss_count | output | 16 | Number of misses |

## Verification
The bench packs three or four distinct addresses into one set, so that eviction order becomes visible at the ports. A victim choice that ignores hits, or that treats hits as fills, turns a later expected hit into a miss, or an expected miss into a hit. One address differs from another only in its upper half, and another only in bits that a plain truncation drops. A hash that uses just the low half, or that skips the fold, places them in different sets, and a line that should have been evicted then still hits. A lookup whose address shares a set with a cached one but has a different upper half shows whether the full tag is compared. Lookups after a flush show whether stale valid bits survive.

// File: rtl/rc_pkg.sv
// Shared definitions for the route cache.
// Assumes a fixed two-way organisation; other widths come from module parameters.
package rc_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        POL_LRU  = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2,
        POL_RSVD = 2'd3
    } repl_pol_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_FILL = 1'b1
    } rc_state_e;
endpackage

// File: rtl/rc_hash.sv
// Folds a destination address into a set number.
// The address halves are XORed, and the result is folded bit by bit modulo IDX_W.
// Assumes ADDR_W is even and IDX_W <= ADDR_W/2.
module rc_hash #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  idx
);
    localparam int HALF = ADDR_W / 2;

    logic [HALF-1:0] fold;

    // XOR the halves, then fold every bit into the index width
    always_comb begin
        fold = addr[ADDR_W-1:HALF] ^ addr[HALF-1:0];
        idx  = '0;
        for (int b = 0; b < HALF; b++) begin
            idx[b % IDX_W] = idx[b % IDX_W] ^ fold[b];
        end
    end
endmodule

// File: rtl/rc_tag_array.sv
// Two-way tag, route and valid storage.
// Reads are combinational on rd_idx. Writes take effect at the clock edge.
// A flush clears all valid bits, and it wins over a write in the same cycle.
module rc_tag_array import rc_pkg::*; #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [ADDR_W-1:0] rd_tag,
    output logic [WAYS-1:0]   hit_way,
    output logic [WAYS-1:0]   set_valid,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_way,
    input  logic [ADDR_W-1:0] wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [DATA_W-1:0] way_data [WAYS];

    for (genvar gw = 0; gw < WAYS; gw++) begin : g_way
        logic [ADDR_W-1:0] tag_q  [SETS];
        logic [DATA_W-1:0] data_q [SETS];
        logic [SETS-1:0]   valid_q;
        logic              sel;

        assign sel = wr_en && !flush && (wr_way == 1'(gw));

        // Valid bits: cleared by reset or flush, set by a fill
        always_ff @(posedge clk) begin
            if (!rst_n || flush) valid_q <= '0;
            else if (sel)        valid_q[wr_idx] <= 1'b1;
        end

        // Tag and route payload storage
        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[wr_idx]  <= wr_tag;
                data_q[wr_idx] <= wr_data;
            end
        end

        assign set_valid[gw] = valid_q[rd_idx];
        assign hit_way[gw]   = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
        assign way_data[gw]  = data_q[rd_idx];

        // R9
        flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (valid_q == '0));
    end

    assign rd_data = hit_way[1] ? way_data[1] : way_data[0];

    // R2
    single_way_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_way));
endmodule

// File: rtl/rc_victim.sv
// Replacement state and victim choice for a two-way set.
// An empty way is always taken first (way 0 before way 1).
// Otherwise the policy picks from a per-set LRU bit, a per-set FIFO pointer,
// or bit 0 of a free-running LFSR. Both bit arrays hold the way to evict next.
module rc_victim import rc_pkg::*; #(
    parameter int          IDX_W     = 4,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       repl_sel,
    input  logic [IDX_W-1:0] set_idx,
    input  logic [WAYS-1:0]  set_valid,
    input  logic             touch_en,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic             fill_way,
    output logic             victim
);
    localparam int          SETS = 1 << IDX_W;
    localparam logic [15:0] TAPS = 16'hB400;

    repl_pol_e       pol;
    logic [SETS-1:0] lru_q;
    logic [SETS-1:0] fifo_q;
    logic [15:0]     lfsr_q;

    assign pol = repl_pol_e'(repl_sel);

    // Free-running Galois LFSR for the random policy
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= {1'b0, lfsr_q[15:1]} ^ (lfsr_q[0] ? TAPS : 16'h0);
    end

    // LRU bit follows hits and fills; FIFO pointer follows fills only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lru_q  <= '0;
            fifo_q <= '0;
        end else begin
            if (fill_en) begin
                lru_q[set_idx]  <= ~fill_way;
                fifo_q[set_idx] <= ~fill_way;
            end else if (touch_en) begin
                lru_q[set_idx]  <= ~touch_way;
            end
        end
    end

    // Pick an empty way first, otherwise apply the selected policy
    always_comb begin
        if (!set_valid[0])      victim = 1'b0;
        else if (!set_valid[1]) victim = 1'b1;
        else begin
            case (pol)
                POL_FIFO: victim = fifo_q[set_idx];
                POL_RAND: victim = lfsr_q[0];
                default:  victim = lru_q[set_idx];
            endcase
        end
    end

    // R8
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != 16'h0);
endmodule

// File: rtl/rc_route_cache.sv
// Top of the route cache.
// A lookup is accepted when req_valid meets req_ready. A hit answers one cycle later.
// A miss parks in the FILL state, holds a full-table request until it is answered,
// installs the answer, and returns it as the result.
// Assumes the full-table engine answers each request exactly once.
module rc_route_cache import rc_pkg::*; #(
    parameter int          ADDR_W    = 32,
    parameter int          IDX_W     = 4,
    parameter int          NH_W      = 8,
    parameter int          PORT_W    = 4,
    parameter int          CNT_W     = 16,
    parameter logic [15:0] LFSR_SEED = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [1:0]        repl_sel,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [NH_W-1:0]   rsp_nh,
    output logic [PORT_W-1:0] rsp_port,
    output logic              slow_req_valid,
    output logic [ADDR_W-1:0] slow_req_addr,
    input  logic              slow_rsp_valid,
    input  logic [NH_W-1:0]   slow_rsp_nh,
    input  logic [PORT_W-1:0] slow_rsp_port,
    output logic [CNT_W-1:0]  hit_count,
    output logic [CNT_W-1:0]  miss_count
);
    localparam int DATA_W = NH_W + PORT_W;

    rc_state_e         state_q;
    logic [ADDR_W-1:0] miss_addr_q;
    logic [ADDR_W-1:0] look_addr;
    logic [IDX_W-1:0]  look_idx;
    logic [WAYS-1:0]   hit_way;
    logic [WAYS-1:0]   set_valid;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] fill_data;
    logic              lk_hit;
    logic              accept;
    logic              fill_en;
    logic              victim;
    logic              rsp_valid_q;
    logic              rsp_hit_q;
    logic [DATA_W-1:0] rsp_data_q;
    logic [CNT_W-1:0]  hit_cnt_q;
    logic [CNT_W-1:0]  miss_cnt_q;

    // While a miss waits, the array is addressed by the parked address
    assign look_addr = (state_q == ST_FILL) ? miss_addr_q : req_addr;
    assign lk_hit    = |hit_way;
    assign req_ready = (state_q == ST_IDLE) && !flush;
    assign accept    = req_valid && req_ready;
    assign fill_en   = (state_q == ST_FILL) && slow_rsp_valid;
    assign fill_data = {slow_rsp_nh, slow_rsp_port};

    rc_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
        .addr (look_addr),
        .idx  (look_idx)
    );

    rc_tag_array #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .rd_idx    (look_idx),
        .rd_tag    (look_addr),
        .hit_way   (hit_way),
        .set_valid (set_valid),
        .rd_data   (rd_data),
        .wr_en     (fill_en),
        .wr_idx    (look_idx),
        .wr_way    (victim),
        .wr_tag    (miss_addr_q),
        .wr_data   (fill_data)
    );

    rc_victim #(.IDX_W(IDX_W), .LFSR_SEED(LFSR_SEED)) u_victim (
        .clk       (clk),
        .rst_n     (rst_n),
        .repl_sel  (repl_sel),
        .set_idx   (look_idx),
        .set_valid (set_valid),
        .touch_en  (accept && lk_hit),
        .touch_way (hit_way[1]),
        .fill_en   (fill_en),
        .fill_way  (victim),
        .victim    (victim)
    );

    // Lookup / fill sequencing, result register and counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            miss_addr_q <= '0;
            rsp_valid_q <= 1'b0;
            rsp_hit_q   <= 1'b0;
            rsp_data_q  <= '0;
            hit_cnt_q   <= '0;
            miss_cnt_q  <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            if (accept) begin
                if (lk_hit) begin
                    rsp_valid_q <= 1'b1;
                    rsp_hit_q   <= 1'b1;
                    rsp_data_q  <= rd_data;
                    hit_cnt_q   <= hit_cnt_q + 1'b1;
                end else begin
                    state_q     <= ST_FILL;
                    miss_addr_q <= req_addr;
                    miss_cnt_q  <= miss_cnt_q + 1'b1;
                end
            end else if (fill_en) begin
                state_q     <= ST_IDLE;
                rsp_valid_q <= 1'b1;
                rsp_hit_q   <= 1'b0;
                rsp_data_q  <= fill_data;
            end
        end
    end

    assign rsp_valid      = rsp_valid_q;
    assign rsp_hit        = rsp_hit_q;
    assign rsp_nh         = rsp_data_q[DATA_W-1:PORT_W];
    assign rsp_port       = rsp_data_q[PORT_W-1:0];
    assign slow_req_valid = (state_q == ST_FILL);
    assign slow_req_addr  = miss_addr_q;
    assign hit_count      = hit_cnt_q;
    assign miss_count     = miss_cnt_q;

    // R3
    hit_fast_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && lk_hit) |=> (rsp_valid && rsp_hit && !slow_req_valid));

    // R4
    no_accept_in_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slow_req_valid |-> !req_ready);

    // R4
    slow_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_req_valid && !slow_rsp_valid) |=> (slow_req_valid && $stable(slow_req_addr)));

    // R5
    fill_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_req_valid && slow_rsp_valid) |=>
            (rsp_valid && !rsp_hit && rsp_nh == $past(slow_rsp_nh) && rsp_port == $past(slow_rsp_port)));

    // R10
    miss_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_req_valid) |-> (miss_count == $past(miss_count) + CNT_W'(1)));
endmodule

// File: tb/rc_route_cache_tb.sv
// Scoreboard bench: lookups push expectations into a queue, and a monitor pops and compares results.
module rc_route_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic [1:0]  repl_sel = 2'd0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_ready;
    logic        rsp_valid, rsp_hit;
    logic [7:0]  rsp_nh;
    logic [3:0]  rsp_port;
    logic        slow_req_valid;
    logic [31:0] slow_req_addr;
    logic        slow_rsp_valid = 1'b0;
    logic [7:0]  slow_rsp_nh = '0;
    logic [3:0]  slow_rsp_port = '0;
    logic [15:0] hit_count, miss_count;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] a;
        bit          hit;
        bit          any;
        string       req;
    } exp_t;
    exp_t exp_q[$];
    logic [31:0] last_addr;

    always #2 clk = ~clk;

    rc_route_cache u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .repl_sel(repl_sel),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_nh(rsp_nh), .rsp_port(rsp_port),
        .slow_req_valid(slow_req_valid), .slow_req_addr(slow_req_addr),
        .slow_rsp_valid(slow_rsp_valid), .slow_rsp_nh(slow_rsp_nh), .slow_rsp_port(slow_rsp_port),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    function automatic logic [7:0] nh_of(input logic [31:0] a);
        return a[7:0] ^ a[23:16] ^ 8'h5A;
    endfunction
    function automatic logic [3:0] port_of(input logic [31:0] a);
        return a[3:0] ^ a[19:16] ^ a[27:24] ^ 4'h3;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: queue the expected result, then present the lookup for one accepted cycle
    task automatic lookup(input logic [31:0] a, input bit hit, input bit any, input string req);
        exp_t e;
        e.a = a; e.hit = hit; e.any = any; e.req = req;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(e);
        last_addr = a;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0 || !req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic do_flush();
        drain();
        flush = 1'b1;
        #1;
        check(req_ready == 1'b0, "R9", "req_ready during flush", 32'(req_ready), 0);
        @(negedge clk);
        flush = 1'b0;
    endtask

    // Slow-path responder: answers each request a few cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && slow_req_valid) begin
                check(slow_req_addr == last_addr, "R4", "slow_req_addr", slow_req_addr, last_addr);
                check(req_ready == 1'b0, "R4", "req_ready while missing", 32'(req_ready), 0);
                repeat (2) @(negedge clk);
                slow_rsp_nh    = nh_of(slow_req_addr);
                slow_rsp_port  = port_of(slow_req_addr);
                slow_rsp_valid = 1'b1;
                @(negedge clk);
                slow_rsp_valid = 1'b0;
            end
        end
    end

    // Monitor: pop the expectation and compare each result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3", "unexpected response", 32'(rsp_valid), 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    if (!e.any)
                        check(rsp_hit == e.hit, e.req, $sformatf("hit flag for %0h", e.a),
                              32'(rsp_hit), 32'(e.hit));
                    check(rsp_nh == nh_of(e.a) && rsp_port == port_of(e.a), e.req,
                          $sformatf("route for %0h", e.a), {20'h0, rsp_nh, rsp_port},
                          {20'h0, nh_of(e.a), port_of(e.a)});
                    if (rsp_hit)
                        check(!slow_req_valid, "R3", "slow request on hit", 32'(slow_req_valid), 0);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    localparam logic [31:0] A = 32'h0000_0011; // set 0
    localparam logic [31:0] B = 32'h0000_0022; // set 0
    localparam logic [31:0] C = 32'h0000_0033; // set 0
    localparam logic [31:0] E = 32'h0000_0012; // set 3
    localparam logic [31:0] F = 32'h0011_0000; // set 0, upper half differs
    localparam logic [31:0] X = 32'h0000_0000; // set 0
    localparam logic [31:0] D = 32'h0001_0001; // set 0 only with both halves folded
    localparam logic [31:0] Y = 32'h0000_0101; // set 0 only with the full bit fold

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
        check(slow_req_valid == 1'b0, "R1", "slow_req_valid", 32'(slow_req_valid), 0);
        check(hit_count == 0 && miss_count == 0, "R1", "counters",
              {hit_count, miss_count}, 0);

        // R6 LRU ordering
        repl_sel = 2'd0;
        lookup(A, 0, 0, "R4");
        lookup(B, 0, 0, "R5");
        lookup(A, 1, 0, "R5");
        lookup(C, 0, 0, "R6");
        lookup(A, 1, 0, "R6");
        lookup(B, 0, 0, "R6");
        lookup(A, 1, 0, "R6");
        lookup(C, 0, 0, "R6");
        // R2 other set untouched, full tag compare
        lookup(E, 0, 0, "R2");
        lookup(E, 1, 0, "R2");
        lookup(A, 1, 0, "R2");
        lookup(F, 0, 0, "R2");
        // R9 flush then miss
        do_flush();
        lookup(A, 0, 0, "R9");
        // R2 hash folding across both halves and all bits
        do_flush();
        lookup(X, 0, 0, "R2");
        lookup(D, 0, 0, "R2");
        lookup(Y, 0, 0, "R2");
        lookup(X, 0, 0, "R2");
        drain();
        // R10 counters: 5 hits, 12 misses
        check(hit_count == 16'd5, "R10", "hit_count", 32'(hit_count), 5);
        check(miss_count == 16'd12, "R10", "miss_count", 32'(miss_count), 12);

        // R7 FIFO ordering
        do_flush();
        repl_sel = 2'd1;
        lookup(A, 0, 0, "R7");
        lookup(B, 0, 0, "R7");
        lookup(A, 1, 0, "R7");
        lookup(C, 0, 0, "R7");
        lookup(B, 1, 0, "R7");
        lookup(A, 0, 0, "R7");
        lookup(C, 1, 0, "R7");

        // R8 random replacement
        do_flush();
        repl_sel = 2'd2;
        lookup(A, 0, 0, "R8");
        lookup(B, 0, 0, "R8");
        lookup(C, 0, 0, "R8");
        lookup(C, 1, 0, "R8");
        lookup(A, 0, 1, "R8");
        drain();
        finish_run();
    end
endmodule